// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous static RAM. It lets a host issue reads and writes on consecutive clock cycles in any mix, with no idle cycle when the data bus changes direction. A read returns its word two active clock cycles after the address is taken. A write takes its address at once and its data two active cycles later. The word is 36 bits wide, in four 9-bit byte lanes, and each lane has its own write enable.

Writes do not reach the array when their data arrives. Each write is held in a pair of pending-write registers and goes into the array only when a later write pushes it out. A read of an address that matches a pending entry gets the array word with the pending lanes laid over it, and the newest write wins. Every read therefore sees all writes issued before it, in issue order.

A load cycle (advance low) starts a read, a write or a deselect. Three chip enables decide whether the chip is selected. An advance-high cycle continues the current operation through a wrapping four-beat burst. A static input picks the burst order: linear or interleaved. Other inputs control the block as follows:
- An active-low clock enable freezes the whole block for the cycles it is high.
- A power-down input stops new operations and turns the outputs off.
- An active-low output enable gates only the output drivers.

Top module: `zsr_sram`

## Requirements
- R1: A read that is loaded at an active edge presents its word on `dq`, with `dq_oe` high, after the second active edge that follows. Reads and writes may be issued on any consecutive active cycles.
- R2: A write takes `din` at the second active edge after its address edge. Lane i is bits [9i+8:9i], and it is written only when `bwe_n[i]` is low on the address cycle (or on the burst beat).
- R3: The chip is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0 on a load cycle. Any other combination is a deselect and leaves memory unchanged.
- R4: A deselect, or a write, drives `dq_oe` low at the same two-cycle latency as a read.
- R5: With `adv`=1, the next beat keeps address bits above bit 1. The low two bits become (base+n) mod 4 when `linear_burst`=1, and base XOR n when `linear_burst`=0. Here n is the beat count since the load.
- R6: A burst continues the operation of its load cycle. A burst that continues a deselect stays deselected.
- R7: A read of an address that has pending writes returns the array word with each pending write's enabled lanes laid over it, the most recent write taking priority. A write is pushed into the array by the second write that follows it.
- R8: While `cke_n`=1 at an edge, all state holds: the commands on that edge are ignored, and `dq` and `dq_oe` do not change.
- R9: While `zz`=1, a sampled command is treated as a deselect (and ends any burst), and `dq_oe` is low at once.
- R10: `oe_n`=1 forces `dq_oe` low without delay and without affecting the pipeline.
- R11: After reset, `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke_n | input | 1 | Clock enable, active low |
| adv | input | 1 | 0 = load a new command, 1 = continue the burst |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| wr_n | input | 1 | 0 = write, 1 = read |
| bwe_n | input | LANES | Byte-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write data, two active cycles after its address |
| linear_burst | input | 1 | 1 = linear burst order, 0 = interleaved |
| oe_n | input | 1 | Output enable, asynchronous, active low |
| zz | input | 1 | Power-down: ignore commands, outputs off |
| dq | output | LANES*LANE_W | Registered read data |
| dq_oe | output | 1 | Output drive enable for `dq` |

## Verification
The bench aims at the hazards of deferred writes. A read that follows one or two writes to the same address with partial lane masks shows whether both pending stages are searched. It also shows whether they are merged in the right order: a design that merged only one stage, or let the older write win, returns stale lanes. Bursts in both orders, started from a non-zero low address, catch a counter that does not wrap or that mixes up the two orders. Bursts that continue a deselect catch a design that wrongly enables `dq_oe`. Stalls, power-down and deselect combinations placed over in-flight reads and writes check three things:
- the pipeline does not move on a held clock;
- write data stays matched to its address across a stall;
- ignored commands leave memory untouched.

// File: rtl/zsr_pkg.sv
`timescale 1ns/1ps
package zsr_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } zsr_op_e;

    // low two address bits of burst beat n from base b
    function automatic logic [1:0] beat_low(input logic [1:0] b, input logic [1:0] n,
                                            input logic linear);
        return linear ? (b + n) : (b ^ n);
    endfunction

endpackage

// File: rtl/zsr_burst_addr.sv
`timescale 1ns/1ps
module zsr_burst_addr
    import zsr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [1:0]        beat,
    input  logic              linear,
    output logic [ADDR_W-1:0] beat_addr
);
    assign beat_addr = {base[ADDR_W-1:2], beat_low(base[1:0], beat, linear)};
endmodule

// File: rtl/zsr_lane_merge.sv
`timescale 1ns/1ps
module zsr_lane_merge #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DW    = LANES * LANE_W
) (
    input  logic [DW-1:0]    base_word,
    input  logic [DW-1:0]    over_word,
    input  logic [LANES-1:0] lane_take,
    output logic [DW-1:0]    merged
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign merged[l*LANE_W +: LANE_W] = lane_take[l] ? over_word[l*LANE_W +: LANE_W]
                                                         : base_word[l*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/zsr_array.sv
`timescale 1ns/1ps
module zsr_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DW    = LANES * LANE_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANES-1:0]  wr_lanes,
    input  logic [DW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]     rd_data
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int l = 0; l < LANES; l++) begin
                if (wr_lanes[l]) cells[wr_addr][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
            end
        end
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/zsr_sram.sv
`timescale 1ns/1ps
module zsr_sram
    import zsr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cke_n,
    input  logic                      adv,
    input  logic                      ce1_n,
    input  logic                      ce2,
    input  logic                      ce3_n,
    input  logic                      wr_n,
    input  logic [LANES-1:0]          bwe_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES*LANE_W-1:0]   din,
    input  logic                      linear_burst,
    input  logic                      oe_n,
    input  logic                      zz,
    output logic [LANES*LANE_W-1:0]   dq,
    output logic                      dq_oe
);
    localparam int DW = LANES * LANE_W;

    typedef struct packed {
        zsr_op_e             op;
        logic [ADDR_W-1:0]   addr;
        logic [LANES-1:0]    lanes;
    } cmd_t;

    typedef struct packed {
        logic                vld;
        logic [ADDR_W-1:0]   addr;
        logic [LANES-1:0]    lanes;
        logic [DW-1:0]       data;
    } pend_t;

    typedef struct packed {
        cmd_t                s1;
        cmd_t                s2;
        zsr_op_e             b_op;
        logic [ADDR_W-1:0]   b_base;
        logic [1:0]          b_cnt;
        pend_t               pw0;
        pend_t               pw1;
        logic [DW-1:0]       rd;
        logic                rd_vld;
    } st_t;

    st_t st_q, st_d;

    logic                active, selected, hit0, hit1, arr_we;
    logic [1:0]          cnt_inc_d;
    logic [ADDR_W-1:0]   beat_addr;
    logic [DW-1:0]       arr_rd, merge1, merge0;

    assign active    = !cke_n;
    assign selected  = !ce1_n && ce2 && !ce3_n;
    assign cnt_inc_d = st_q.b_cnt + 2'd1;
    assign hit1      = st_q.pw1.vld && (st_q.pw1.addr == st_q.s2.addr);
    assign hit0      = st_q.pw0.vld && (st_q.pw0.addr == st_q.s2.addr);

    zsr_burst_addr #(.ADDR_W(ADDR_W)) u_burst (
        .base      (st_q.b_base),
        .beat      (cnt_inc_d),
        .linear    (linear_burst),
        .beat_addr (beat_addr)
    );

    zsr_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk      (clk),
        .wr_en    (arr_we),
        .wr_addr  (st_q.pw1.addr),
        .wr_lanes (st_q.pw1.lanes),
        .wr_data  (st_q.pw1.data),
        .rd_addr  (st_q.s2.addr),
        .rd_data  (arr_rd)
    );

    // older pending write first, newer one laid on top
    zsr_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge_old (
        .base_word (arr_rd),
        .over_word (st_q.pw1.data),
        .lane_take (st_q.pw1.lanes & {LANES{hit1}}),
        .merged    (merge1)
    );

    zsr_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge_new (
        .base_word (merge1),
        .over_word (st_q.pw0.data),
        .lane_take (st_q.pw0.lanes & {LANES{hit0}}),
        .merged    (merge0)
    );

    always_comb begin
        st_d   = st_q;
        arr_we = 1'b0;
        if (active) begin
            if (zz) begin
                st_d.s1.op    = OP_IDLE;
                st_d.s1.addr  = addr;
                st_d.s1.lanes = '0;
                st_d.b_op     = OP_IDLE;
            end else if (!adv) begin
                st_d.s1.op    = selected ? (wr_n ? OP_READ : OP_WRITE) : OP_IDLE;
                st_d.s1.addr  = addr;
                st_d.s1.lanes = ~bwe_n;
                st_d.b_op     = st_d.s1.op;
                st_d.b_base   = addr;
                st_d.b_cnt    = 2'd0;
            end else begin
                st_d.s1.op    = st_q.b_op;
                st_d.s1.addr  = beat_addr;
                st_d.s1.lanes = ~bwe_n;
                st_d.b_cnt    = cnt_inc_d;
            end
            st_d.s2 = st_q.s1;
            case (st_q.s2.op)
                OP_WRITE: begin
                    st_d.pw0.vld   = 1'b1;
                    st_d.pw0.addr  = st_q.s2.addr;
                    st_d.pw0.lanes = st_q.s2.lanes;
                    st_d.pw0.data  = din;
                    st_d.pw1       = st_q.pw0;
                    arr_we         = st_q.pw1.vld;
                    st_d.rd_vld    = 1'b0;
                end
                OP_READ: begin
                    st_d.rd     = merge0;
                    st_d.rd_vld = 1'b1;
                end
                default: st_d.rd_vld = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dq    = st_q.rd;
    assign dq_oe = st_q.rd_vld && !oe_n && !zz;

    assert_read_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (active && st_q.s2.op == OP_READ) |=> st_q.rd_vld);

    assert_write_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && st_q.s2.op == OP_WRITE) |=> (st_q.pw0.vld && st_q.pw0.addr == $past(st_q.s2.addr)));

    assert_unselected_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !zz && !adv && !(!ce1_n && ce2 && !ce3_n)) |=> st_q.s1.op == OP_IDLE);

    assert_nonread_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && st_q.s2.op != OP_READ) |=> !st_q.rd_vld);

    assert_stall_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(st_q.rd) && $stable(st_q.rd_vld) && $stable(st_q.s1) && $stable(st_q.pw0)));

    assert_sleep_ignores_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && zz) |=> st_q.s1.op == OP_IDLE);
endmodule

// File: tb/zsr_sram_bench.sv
`timescale 1ns/1ps
module zsr_sram_bench;
    localparam int K_ID = 0, K_RD = 1, K_WR = 2;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cke_n = 1'b0, adv = 1'b0, ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1, wr_n = 1'b1;
    logic [3:0]  bwe_n = 4'hF;
    logic [5:0]  addr = '0;
    logic [35:0] din = '0;
    logic        linear_burst = 1'b1, oe_n = 1'b0, zz = 1'b0;
    logic [35:0] dq;
    logic        dq_oe;

    int checks = 0, errors = 0;

    zsr_sram u_zsr_sram (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .adv(adv), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .wr_n(wr_n), .bwe_n(bwe_n), .addr(addr), .din(din),
        .linear_burst(linear_burst), .oe_n(oe_n), .zz(zz), .dq(dq), .dq_oe(dq_oe)
    );

    always #10 clk = ~clk;

    // reference state
    logic [35:0] ref_mem [64];
    int          bb_kind = K_ID;
    logic [5:0]  bb_base = '0;
    logic [1:0]  bb_cnt = '0;
    logic        zz_next = 1'b0, oen_next = 1'b0, lin_next = 1'b1;
    // issued-command pipeline: p0 newest, o = now on the output
    int          p0_kind = K_ID, p1_kind = K_ID, o_kind = K_ID;
    logic [35:0] p0_exp, p1_exp, o_exp, p0_wd = '0, p1_wd = '0;
    string       p0_tag = "", p1_tag = "", o_tag = "";
    int          filled = 0;

    task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_out();
        logic e_oe;
        if (filled >= 3) begin
            e_oe = (o_kind == K_RD) && !oe_n && !zz;
            chk(dq_oe === e_oe, o_tag, {35'b0, dq_oe}, {35'b0, e_oe});
            if (e_oe) chk(dq === o_exp, o_tag, dq, o_exp);
        end
    endtask

    task automatic step(input logic a_adv, input logic [2:0] ce, input logic a_wr,
                        input logic [5:0] a, input logic [3:0] en, input logic [35:0] wd,
                        input logic stall, input string tag);
        int          kind;
        logic [5:0]  eff;
        logic [35:0] e;
        @(negedge clk);
        check_out();
        cke_n = stall; adv = a_adv; {ce1_n, ce2, ce3_n} = ce; wr_n = !a_wr;
        addr = a; bwe_n = ~en; din = p1_wd; zz = zz_next; oe_n = oen_next;
        linear_burst = lin_next;
        kind = K_ID; eff = a; e = '0;
        if (!stall) begin
            if (zz_next) begin
                bb_kind = K_ID;
            end else if (!a_adv) begin
                kind = (ce == 3'b010) ? (a_wr ? K_WR : K_RD) : K_ID;
                bb_kind = kind; bb_base = a; bb_cnt = 2'd0;
            end else begin
                bb_cnt = bb_cnt + 2'd1;
                kind = bb_kind;
                eff = {bb_base[5:2], lin_next ? bb_base[1:0] + bb_cnt : bb_base[1:0] ^ bb_cnt};
            end
            if (kind == K_WR)
                for (int l = 0; l < 4; l++) if (en[l]) ref_mem[eff][l*9 +: 9] = wd[l*9 +: 9];
            if (kind == K_RD) e = ref_mem[eff];
        end
        @(posedge clk);
        if (!stall) begin
            o_kind = p1_kind; o_exp = p1_exp; o_tag = p1_tag;
            p1_kind = p0_kind; p1_exp = p0_exp; p1_tag = p0_tag; p1_wd = p0_wd;
            p0_kind = kind; p0_exp = e; p0_tag = tag; p0_wd = wd;
            if (filled < 3) filled++;
        end
    endtask

    task automatic rd(input logic [5:0] a, input string tag);
        step(1'b0, 3'b010, 1'b0, a, 4'h0, '0, 1'b0, tag);
    endtask
    task automatic wr(input logic [5:0] a, input logic [3:0] en, input logic [35:0] d, input string tag);
        step(1'b0, 3'b010, 1'b1, a, en, d, 1'b0, tag);
    endtask
    task automatic nop(input string tag);
        step(1'b0, 3'b110, 1'b0, '0, 4'h0, '0, 1'b0, tag);
    endtask
    task automatic beat(input logic [3:0] en, input logic [35:0] d, input string tag);
        step(1'b1, 3'b010, 1'b0, '0, en, d, 1'b0, tag);
    endtask

    task automatic t_reset();
        #1;
        chk(dq_oe === 1'b0, "R11", {35'b0, dq_oe}, 36'd0);
        @(negedge clk); rst_n = 1'b1;
        chk(dq_oe === 1'b0, "R11", {35'b0, dq_oe}, 36'd0);
    endtask

    task automatic t_fill();
        for (int i = 0; i < 64; i++) wr(6'(i), 4'hF, 36'(i) * 36'h0_0102_0304 + 36'h5_A5A5_A5A5, "R2");
        nop("R4"); nop("R4");
    endtask

    task automatic t_read_mix();
        rd(6'd3, "R1"); rd(6'd40, "R1"); wr(6'd41, 4'hF, 36'h1_2345_6789, "R2");
        rd(6'd41, "R1"); wr(6'd3, 4'h1, 36'hF_FFFF_FFFF, "R2"); rd(6'd3, "R2");
        rd(6'd63, "R1"); nop("R4"); nop("R4");
    endtask

    task automatic t_coherency();
        wr(6'd12, 4'h3, 36'hA_AAAA_AAAA, "R7");
        wr(6'd12, 4'h6, 36'h5_5555_5555, "R7");
        rd(6'd12, "R7");
        wr(6'd30, 4'hF, 36'h0_0000_0001, "R7");
        rd(6'd12, "R7");
        wr(6'd31, 4'hF, 36'h0_0000_0002, "R7");
        rd(6'd12, "R7"); rd(6'd30, "R7");
        nop("R4"); nop("R4");
    endtask

    task automatic t_burst();
        lin_next = 1'b1;
        rd(6'd6, "R5"); beat(4'h0, '0, "R5"); beat(4'h0, '0, "R5"); beat(4'h0, '0, "R5");
        beat(4'h0, '0, "R5");
        nop("R4");
        lin_next = 1'b0;
        wr(6'd9, 4'hF, 36'h1_1111_1111, "R6"); beat(4'hF, 36'h2_2222_2222, "R6");
        beat(4'h5, 36'h3_3333_3333, "R6"); beat(4'hF, 36'h4_4444_4444, "R6");
        rd(6'd9, "R6"); beat(4'h0, '0, "R5"); beat(4'h0, '0, "R5"); beat(4'h0, '0, "R5");
        nop("R6"); beat(4'hF, 36'h7_7777_7777, "R6"); beat(4'h0, '0, "R6");
        lin_next = 1'b1;
        rd(6'd8, "R5"); rd(6'd0, "R6");
        nop("R4"); nop("R4");
    endtask

    task automatic t_deselect();
        logic [2:0] combos [7] = '{3'b000, 3'b001, 3'b011, 3'b100, 3'b101, 3'b110, 3'b111};
        for (int i = 0; i < 7; i++) step(1'b0, combos[i], 1'b1, 6'd20, 4'hF, 36'(i + 1), 1'b0, "R4");
        rd(6'd20, "R3"); nop("R4"); nop("R4");
    endtask

    task automatic t_stall();
        rd(6'd5, "R8"); wr(6'd5, 4'hF, 36'h9_8765_4321, "R8");
        step(1'b0, 3'b010, 1'b1, 6'd7, 4'hF, 36'hD_EAD0_BEEF, 1'b1, "R8");
        step(1'b0, 3'b010, 1'b0, 6'd7, 4'h0, '0, 1'b1, "R8");
        rd(6'd5, "R8");
        step(1'b1, 3'b010, 1'b0, 6'd0, 4'h0, '0, 1'b1, "R8");
        step(1'b1, 3'b010, 1'b0, 6'd0, 4'h0, '0, 1'b1, "R8");
        rd(6'd7, "R8"); nop("R4"); nop("R4");
    endtask

    task automatic t_sleep();
        rd(6'd33, "R9"); rd(6'd34, "R9");
        zz_next = 1'b1;
        wr(6'd33, 4'hF, 36'h0_FEED_FACE, "R9"); nop("R9"); nop("R9");
        zz_next = 1'b0;
        rd(6'd33, "R9"); nop("R4"); nop("R4");
    endtask

    task automatic t_oe();
        rd(6'd50, "R10"); rd(6'd51, "R10");
        oen_next = 1'b1;
        rd(6'd52, "R10");
        oen_next = 1'b0;
        nop("R10"); nop("R4"); nop("R4");
    endtask

    task automatic t_random();
        for (int i = 0; i < 400; i++) begin
            logic a_adv, stall, a_wr;
            logic [2:0] ce;
            a_adv = ($urandom_range(0, 3) == 0);
            stall = ($urandom_range(0, 9) == 0);
            a_wr  = $urandom_range(0, 1) == 1;
            ce    = ($urandom_range(0, 7) == 0) ? 3'(($urandom_range(0, 3) << 1) | 3'b001) : 3'b010;
            step(a_adv, ce, a_wr, 6'($urandom_range(0, 7)), 4'($urandom_range(0, 15)),
                 {4'($urandom), 32'($urandom)}, stall, "R7");
        end
        nop("R4"); nop("R4"); nop("R4");
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_fill();
        t_read_mix();
        t_coherency();
        t_burst();
        t_deselect();
        t_stall();
        t_sleep();
        t_oe();
        t_random();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule